// File: doc/BRIEF.md
# Word-to-Halfword Access Splitter

This block joins a 32-bit internal request port to an external bus cycle engine that moves 16 bits per cycle. A word request becomes two halfword cycles: the lower halfword goes first and the upper halfword follows at the next halfword address. Byte and halfword requests go through as a single cycle, with byte-lane enables set to match. For a word read, the two returned halfwords are merged into one 32-bit result. The requester then receives a single acknowledge.

The block also tells the cycle engine how to treat chip select between the two halves. On a split write, a hold flag goes out with the first half and the second half follows at once, so chip select stays active across both. On a split read the flag stays clear, and the block leaves one idle clock between the halves so that chip select drops. The engine controls strobe timing. This block handles sequencing, address stepping, lane selection and read merging.

Requests are accepted only while the block is idle. The engine holds `cyc_done` high for one clock to end a cycle. Request size encoding: 2'b00 byte, 2'b01 halfword, 2'b10 or 2'b11 word.

Top module: `word_splitter`

## Requirements
- R1: While reset is held and after it releases, `req_ready` is 1, `cyc_valid` is 0 and `rsp_ack` is 0 until a request is accepted.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the clock that presents the acknowledge.
- R3: A word request issues exactly two cycles. The first is at halfword address N = {req_addr[AW-1:2],0} with write data req_wdata[15:0]. The second is at N+1 with req_wdata[31:16]. Both have `cyc_be` = 2'b11.
- R4: On a split write, `cyc_hold_cs` is 1 during the first half and 0 during the second. `cyc_valid` stays 1 from the first half straight into the second.
- R5: On a split read, `cyc_hold_cs` is 0 throughout, and `cyc_valid` is 0 for exactly one clock between the two halves.
- R6: A word read returns `rsp_rdata` = {second halfword, first halfword}.
- R7: A byte request issues one cycle at halfword address req_addr[AW-1:1]. An even address gives `cyc_be` = 2'b01 with data {8'h00, req_wdata[7:0]}. An odd address gives 2'b10 with data {req_wdata[7:0], 8'h00}. A byte read returns the enabled lane, zero-extended.
- R8: A halfword request issues one cycle at req_addr[AW-1:1] (bit 0 ignored), with `cyc_be` = 2'b11 and data req_wdata[15:0]. A halfword read returns the halfword, zero-extended.
- R9: Each request produces exactly one `rsp_ack` pulse, one clock wide, in the clock after the `cyc_done` of its last cycle.
- R10: While `cyc_valid` is 1 and `cyc_done` is 0, `cyc_addr`, `cyc_be`, `cyc_wdata`, `cyc_write` and `cyc_hold_cs` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_ack |
| cyc_valid | output | 1 | Halfword cycle requested |
| cyc_write | output | 1 | Cycle direction |
| cyc_addr | output | AW-1 | Halfword address |
| cyc_be | output | 2 | Byte-lane enables, bit 0 = low lane |
| cyc_wdata | output | 16 | Write data; disabled lanes are zero |
| cyc_hold_cs | output | 1 | Keep chip select active into the next cycle |
| cyc_done | input | 1 | Engine finished the current cycle |
| cyc_rdata | input | 16 | Read data, valid with cyc_done |

## Verification
The properties assume that the engine raises `cyc_done` only while `cyc_valid` is 1, for one clock per cycle. They also assume that `cyc_rdata` is meaningful only alongside that pulse. The bench's engine model keeps to this. It sets `cyc_done` only after it has seen `cyc_valid`, clears it on the next clock, and varies the latency between one and three clocks. Requests are offered only while `req_ready` is 1, and `req_valid` is dropped right after acceptance.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = HALF_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_GAP  = 2'd2,
    ST_HI   = 2'd3
  } seq_state_t;

  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction
endpackage

// File: rtl/ws_seq.sv
module ws_seq
  import ws_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          cyc_done,
  output logic          req_ready,
  output logic          ld,
  output logic          cyc_valid,
  output logic          hi_sel,
  output logic          hold_cs,
  output logic          r_write,
  output logic [1:0]    r_size,
  output logic          r_bsel,
  output logic [AW-2:0] cyc_addr,
  output logic          lo_done,
  output logic          last_done
);
  seq_state_t    state, state_nxt;
  logic [AW-2:0] r_hw;
  logic [AW-2:0] hw_nxt;
  logic          wd;

  assign wd        = is_word(r_size);
  assign req_ready = (state == ST_IDLE);
  assign ld        = req_ready && req_valid;
  assign cyc_valid = (state == ST_LO) || (state == ST_HI);
  assign hi_sel    = (state == ST_HI);
  assign hold_cs   = r_write && wd && (state == ST_LO);
  assign cyc_addr  = hi_sel ? r_hw + 1'b1 : r_hw;
  assign lo_done   = cyc_done && (state == ST_LO) && wd;
  assign last_done = cyc_done && (((state == ST_LO) && !wd) || (state == ST_HI));
  assign hw_nxt    = is_word(req_size) ? {req_addr[AW-1:2], 1'b0} : req_addr[AW-1:1];

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: if (req_valid) state_nxt = ST_LO;
      ST_LO:   if (cyc_done) begin
                 if (!wd)          state_nxt = ST_IDLE;
                 else if (r_write) state_nxt = ST_HI;
                 else              state_nxt = ST_GAP;
               end
      ST_GAP:  state_nxt = ST_HI;
      ST_HI:   if (cyc_done) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_write <= 1'b0;
      r_size  <= 2'b00;
      r_bsel  <= 1'b0;
      r_hw    <= '0;
    end else begin
      state <= state_nxt;
      if (ld) begin
        r_write <= req_write;
        r_size  <= req_size;
        r_bsel  <= req_addr[0];
        r_hw    <= hw_nxt;
      end
    end
  end
endmodule

// File: rtl/ws_lane.sv
module ws_lane
  import ws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [1:0]        r_size,
  input  logic              r_bsel,
  input  logic              hi_sel,
  output logic [LANES-1:0]  cyc_be,
  output logic [HALF_W-1:0] cyc_wdata
);
  logic [WORD_W-1:0] r_wdata;
  logic [HALF_W-1:0] src;
  logic              multi;

  assign multi = is_word(r_size) || (r_size == 2'b01);

  always_comb begin
    if (is_word(r_size) && hi_sel) src = r_wdata[WORD_W-1:HALF_W];
    else                           src = r_wdata[HALF_W-1:0];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      cyc_be[i] = multi || (r_bsel == i[0]);
      if (!cyc_be[i])  cyc_wdata[i*8 +: 8] = 8'h00;
      else if (multi)  cyc_wdata[i*8 +: 8] = src[i*8 +: 8];
      else             cyc_wdata[i*8 +: 8] = r_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  r_wdata <= '0;
    else if (ld) r_wdata <= req_wdata;
  end
endmodule

// File: rtl/ws_asm.sv
module ws_asm
  import ws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_done,
  input  logic              last_done,
  input  logic              r_write,
  input  logic [1:0]        r_size,
  input  logic              r_bsel,
  input  logic [HALF_W-1:0] cyc_rdata,
  output logic              rsp_ack,
  output logic [WORD_W-1:0] rsp_rdata
);
  logic [HALF_W-1:0] lo_q;
  logic [WORD_W-1:0] rd_nxt;
  logic              rd_en;

  assign rd_en = last_done && !r_write;

  always_comb begin
    if (is_word(r_size))     rd_nxt = {cyc_rdata, lo_q};
    else if (r_size == 2'b01) rd_nxt = {{HALF_W{1'b0}}, cyc_rdata};
    else if (r_bsel)          rd_nxt = {{(WORD_W-8){1'b0}}, cyc_rdata[15:8]};
    else                      rd_nxt = {{(WORD_W-8){1'b0}}, cyc_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack <= last_done;
      if (lo_done) lo_q      <= cyc_rdata;
      if (rd_en)   rsp_rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/word_splitter.sv
module word_splitter
  import ws_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_ack,
  output logic [31:0]   rsp_rdata,
  output logic          cyc_valid,
  output logic          cyc_write,
  output logic [AW-2:0] cyc_addr,
  output logic [1:0]    cyc_be,
  output logic [15:0]   cyc_wdata,
  output logic          cyc_hold_cs,
  input  logic          cyc_done,
  input  logic [15:0]   cyc_rdata
);
  logic       ld, hi_sel, r_write, r_bsel, lo_done, last_done;
  logic [1:0] r_size;

  ws_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .cyc_done(cyc_done),
    .req_ready(req_ready), .ld(ld), .cyc_valid(cyc_valid), .hi_sel(hi_sel),
    .hold_cs(cyc_hold_cs), .r_write(r_write), .r_size(r_size), .r_bsel(r_bsel),
    .cyc_addr(cyc_addr), .lo_done(lo_done), .last_done(last_done)
  );

  ws_lane u_lane (
    .clk(clk), .rst_n(rst_n), .ld(ld), .req_wdata(req_wdata), .r_size(r_size),
    .r_bsel(r_bsel), .hi_sel(hi_sel), .cyc_be(cyc_be), .cyc_wdata(cyc_wdata)
  );

  ws_asm u_asm (
    .clk(clk), .rst_n(rst_n), .lo_done(lo_done), .last_done(last_done),
    .r_write(r_write), .r_size(r_size), .r_bsel(r_bsel), .cyc_rdata(cyc_rdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
  );

  assign cyc_write = r_write;
endmodule

// File: rtl/ws_chk.sv
module ws_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_ack,
  input logic          cyc_valid,
  input logic          cyc_write,
  input logic [AW-2:0] cyc_addr,
  input logic [1:0]    cyc_be,
  input logic [15:0]   cyc_wdata,
  input logic          cyc_hold_cs,
  input logic          cyc_done
);
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cyc_valid);

  a_r4_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_hold_cs |-> (cyc_write && cyc_valid));

  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_hold_cs && cyc_done) |=>
      (cyc_valid && !cyc_hold_cs && cyc_addr == $past(cyc_addr) + 1'b1));

  a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_done && !cyc_write) |=> !cyc_valid);

  a_r7_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_be != 2'b00));

  a_r9_ack_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(cyc_done));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_done) |=>
      (cyc_valid && $stable(cyc_addr) && $stable(cyc_be) && $stable(cyc_wdata)
       && $stable(cyc_write) && $stable(cyc_hold_cs)));
endmodule

bind word_splitter ws_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_ack(rsp_ack),
  .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
  .cyc_be(cyc_be), .cyc_wdata(cyc_wdata), .cyc_hold_cs(cyc_hold_cs),
  .cyc_done(cyc_done)
);

// File: tb/word_splitter_test.sv
module word_splitter_test;
  localparam int AW = 24;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [23:0] addr;
    logic [31:0] wd;
    logic [1:0]  lat;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{1'b1, 2'd2, 24'h000100, 32'hDEADBEEF, 2'd1},
    '{1'b0, 2'd2, 24'h000104, 32'h0,        2'd2},
    '{1'b1, 2'd1, 24'h000203, 32'h5555CAFE, 2'd1},
    '{1'b0, 2'd1, 24'h000206, 32'h0,        2'd3},
    '{1'b1, 2'd0, 24'h000301, 32'h000000A7, 2'd2},
    '{1'b1, 2'd0, 24'h000300, 32'h1234565E, 2'd1},
    '{1'b0, 2'd0, 24'h000301, 32'h0,        2'd1},
    '{1'b0, 2'd0, 24'h000300, 32'h0,        2'd2},
    '{1'b0, 2'd2, 24'hFFFFFE, 32'h0,        2'd3},
    '{1'b1, 2'd3, 24'h7ABCD4, 32'h13572468, 2'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          req_ready, rsp_ack;
  logic [31:0]   rsp_rdata;
  logic          cyc_valid, cyc_write, cyc_hold_cs, cyc_done;
  logic [AW-2:0] cyc_addr;
  logic [1:0]    cyc_be;
  logic [15:0]   cyc_wdata, cyc_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  word_splitter #(.AW(AW)) uut (.*);

  function automatic logic [15:0] mem_f(input logic [AW-2:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    logic [AW-2:0] n_hw, a_seen [2];
    logic [1:0]    be_seen [2];
    logic [15:0]   wd_seen [2];
    logic          hold_seen [2];
    logic [1:0]    be_exp;
    logic [15:0]   wd_exp, hw_lo, hw_hi;
    logic [31:0]   rd_exp, rd_got;
    int n = 0, gap = 0, cnt = 0, busy = 0, stab = 0, ack_k = -1, done_k = -10;
    bit in_cyc = 0;
    bit word = v.sz[1];

    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = v.wr; req_size = v.sz;
    req_addr = v.addr; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (k > 0) @(negedge clk);
      cyc_done = 1'b0;
      if (rsp_ack) begin ack_k = k; rd_got = rsp_rdata; break; end
      if (req_ready) busy++;
      if (cyc_valid) begin
        cyc_rdata = mem_f(cyc_addr);
        if (!in_cyc) begin
          if (n < 2) begin
            a_seen[n] = cyc_addr; be_seen[n] = cyc_be;
            wd_seen[n] = cyc_wdata; hold_seen[n] = cyc_hold_cs;
          end
          n++; in_cyc = 1; cnt = 0;
        end else if (n <= 2) begin
          if (cyc_addr != a_seen[n-1] || cyc_be != be_seen[n-1] ||
              cyc_wdata != wd_seen[n-1] || cyc_hold_cs != hold_seen[n-1] ||
              cyc_write != v.wr) stab++;
        end
        cnt++;
        if (cnt >= v.lat) begin cyc_done = 1'b1; in_cyc = 0; done_k = k; end
      end else if (n == 1) gap++;
    end

    n_hw = word ? {v.addr[23:2], 1'b0} : v.addr[23:1];
    chk(n == (word ? 2 : 1), word ? "R3 cycle count" : "R8/R7 single cycle",
        n, word ? 2 : 1);
    if (n < 1) return;
    chk(a_seen[0] == n_hw, "R3 R7 R8 first address", {9'b0, a_seen[0]}, {9'b0, n_hw});
    if (!word && v.sz == 2'd0)
      be_exp = v.addr[0] ? 2'b10 : 2'b01;
    else
      be_exp = 2'b11;
    chk(be_seen[0] == be_exp, "R7 R8 lane enables", {30'b0, be_seen[0]}, {30'b0, be_exp});
    if (v.wr) begin
      if (v.sz == 2'd0) wd_exp = v.addr[0] ? {v.wd[7:0], 8'h00} : {8'h00, v.wd[7:0]};
      else              wd_exp = v.wd[15:0];
      chk(wd_seen[0] == wd_exp, "R3 R7 R8 first write data", {16'b0, wd_seen[0]}, {16'b0, wd_exp});
    end
    chk(hold_seen[0] == (v.wr && word), "R4 R5 hold flag first half",
        {31'b0, hold_seen[0]}, {31'b0, v.wr && word});
    if (word && n == 2) begin
      chk(a_seen[1] == n_hw + 1'b1, "R3 second address", {9'b0, a_seen[1]}, {9'b0, n_hw + 1'b1});
      chk(be_seen[1] == 2'b11, "R3 second lanes", {30'b0, be_seen[1]}, 32'd3);
      if (v.wr) begin
        chk(wd_seen[1] == v.wd[31:16], "R3 second write data", {16'b0, wd_seen[1]}, {16'b0, v.wd[31:16]});
        chk(hold_seen[1] == 1'b0, "R4 hold flag second half", {31'b0, hold_seen[1]}, 32'd0);
        chk(gap == 0, "R4 no gap between write halves", gap, 0);
      end else begin
        chk(gap == 1, "R5 one idle clock between read halves", gap, 1);
      end
    end
    chk(ack_k == done_k + 1, "R9 ack one clock after last done", ack_k, done_k + 1);
    chk(busy == 0, "R2 ready low while busy", busy, 0);
    chk(stab == 0, "R10 fields stable within a cycle", stab, 0);
    if (!v.wr) begin
      hw_lo = mem_f(n_hw);
      hw_hi = mem_f(n_hw + 1'b1);
      if (word)             rd_exp = {hw_hi, hw_lo};
      else if (v.sz == 2'd1) rd_exp = {16'h0, hw_lo};
      else                   rd_exp = {24'h0, v.addr[0] ? hw_lo[15:8] : hw_lo[7:0]};
      chk(rd_got == rd_exp, word ? "R6 merged read word" : "R7 R8 read result", rd_got, rd_exp);
    end
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R9 single ack pulse", {31'b0, rsp_ack}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; cyc_done = 1'b0; cyc_rdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !cyc_valid && !rsp_ack, "R1 reset state",
        {29'b0, req_ready, cyc_valid, rsp_ack}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cyc_valid && !rsp_ack, "R1 state after release",
        {29'b0, req_ready, cyc_valid, rsp_ack}, 32'd4);

    for (int i = 0; i < 10; i++) run(VEC[i]);

    // R1: reset in the middle of a split read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 24'h000400;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cyc_valid == 1'b1, "R3 cycle started", {31'b0, cyc_valid}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk(req_ready && !cyc_valid, "R1 reset mid-transfer",
        {30'b0, req_ready, cyc_valid}, 32'd2);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rsp_ack && !cyc_valid, "R1 no ack after reset",
        {30'b0, rsp_ack, cyc_valid}, 32'd0);

    run(VEC[0]);
    run(VEC[8]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule